// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

The controller sits between a synchronous host port and an external byte-wide asynchronous static RAM. The host offers one read or write at a time with a valid/ready handshake, a 19-bit address and a byte of data. The controller turns each request into a timed sequence of active-low chip-select, output-enable and write-enable strobes, and it drives the shared data bus through separate output, output-enable and input signals.

Every analog interval is given in nanoseconds as a parameter. Each one is rounded up to whole clock cycles using `CLK_PERIOD_NS`. Reads hold the select and output-enable low until the slowest of the address, select and output-enable access times has passed. The byte sampled at that point is returned with a one-cycle valid pulse.

Writes work differently. The controller treats the write as the span in which select and write-enable are both low. It keeps output-enable high for the whole write, and it drives the bus one cycle before the pulse starts and releases it one cycle after the pulse ends. After a read, the controller releases the bus for a set turnaround window before anything can drive it again.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0 and `rsp_valid` is 0. After reset, `req_ready` is 1.
- R2: `req_ready` is 1 only when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` then stays 0 for the whole access. With the defaults, that is 11 cycles for a write and 15 cycles for a read.
- R3: A read (`req_write`=0) holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for RD_CYC cycles. RD_CYC is ceil(max(T_RC_NS, T_AA_NS, T_CO_NS, T_OE_NS)/CLK_PERIOD_NS), which is 11 by default. The bus is sampled at the end of the last of those cycles. `rsp_valid` then pulses high for exactly one cycle, with the sampled byte on `rsp_rdata`.
- R4: A write (`req_write`=1) keeps `sram_oe_n`=1 throughout. `sram_we_n` is 0 only while `sram_cs_n` is 0, and it is 0 for exactly WP_CYC consecutive cycles. WP_CYC is ceil(max(T_WP_NS, T_DW_NS)/CLK_PERIOD_NS), which is 8 by default.
- R5: During a write, `sram_dq_oe` becomes 1 one cycle before `sram_we_n` falls and becomes 0 one cycle after `sram_we_n` rises. `sram_dq_out` equals the request byte and stays stable while `sram_dq_oe` is 1.
- R6: `sram_addr` stays stable for every cycle in which `sram_cs_n` stays 0.
- R7: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, nor within TA_CYC cycles after `sram_oe_n` rises. TA_CYC is ceil(T_RELEASE_NS/CLK_PERIOD_NS), which is 4 by default. With a request waiting, a read's select fall is followed by the next select fall 16 cycles later.
- R8: The span from a write's select fall to the next access's select fall is at least ceil(T_WC_NS/CLK_PERIOD_NS) cycles. By default it is 12 cycles when a request is waiting.
- R9: A request that is offered and withdrawn while `req_ready` is 0 has no effect. No extra select fall occurs, and no byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 19 | Address to the RAM |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the data bus |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The bench builds the controller with its default values. Those are a 5 ns clock and the 55 ns access grade, which give an 11-cycle read window, an 8-cycle write pulse and a 4-cycle release window. These small counts make it practical to measure every strobe to the exact cycle.

The RAM model returns a garbage byte until the read window has fully elapsed, so a read sampled one cycle early is detected. The model keeps driving the bus for the release window after output-enable rises, so a turnaround that is one cycle short appears as contention. Back-to-back requests expose the exact select-fall spacing after a write and after a read.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_CO_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 40,
  parameter int T_DW_NS       = 25,
  parameter int T_RELEASE_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RD_NS0   = (T_AA_NS > T_CO_NS) ? T_AA_NS : T_CO_NS;
  localparam int RD_NS1   = (RD_NS0 > T_OE_NS) ? RD_NS0 : T_OE_NS;
  localparam int RD_NS    = (RD_NS1 > T_RC_NS) ? RD_NS1 : T_RC_NS;
  localparam int WP_NS    = (T_WP_NS > T_DW_NS) ? T_WP_NS : T_DW_NS;
  localparam int RD_RAW   = (RD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WP_RAW   = (WP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TA_RAW   = (T_RELEASE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WC_CYC   = (T_WC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC   = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_CYC   = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int TA_CYC   = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int WREC_CYC = (WC_CYC > WP_CYC + 3) ? WC_CYC - WP_CYC - 2 : 1;
  localparam int MAX0     = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX1     = (MAX0 > TA_CYC) ? MAX0 : TA_CYC;
  localparam int MAXC     = (MAX1 > WREC_CYC) ? MAX1 : WREC_CYC;
  localparam int CNT_W    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_WSET, S_WPULSE, S_WHOLD, S_WREC
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done;

  assign req_ready = (state == S_IDLE);
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sram_addr   <= '0;
      sram_cs_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          sram_cs_n <= 1'b0;
          if (req_write) begin
            sram_dq_out <= req_wdata;
            sram_dq_oe  <= 1'b1;
            state       <= S_WSET;
          end else begin
            sram_oe_n <= 1'b0;
            cnt       <= CNT_W'(RD_CYC - 1);
            state     <= S_READ;
          end
        end
        S_READ: if (cnt_done) begin
          rsp_rdata <= sram_dq_in;
          rsp_valid <= 1'b1;
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          cnt       <= CNT_W'(TA_CYC - 1);
          state     <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt_done) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_WSET: begin
          sram_we_n <= 1'b0;
          cnt       <= CNT_W'(WP_CYC - 1);
          state     <= S_WPULSE;
        end
        S_WPULSE: if (cnt_done) begin
          sram_we_n <= 1'b1;
          state     <= S_WHOLD;
        end else cnt <= cnt - 1'b1;
        S_WHOLD: begin
          sram_dq_oe <= 1'b0;
          sram_cs_n  <= 1'b1;
          cnt        <= CNT_W'(WREC_CYC - 1);
          state      <= S_WREC;
        end
        S_WREC: if (cnt_done) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int TA_CYC = 4,
  parameter int WP_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  logic [15:0] since_oe;
  logic [15:0] we_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_oe <= 16'hFFFF;
      we_len   <= '0;
    end else begin
      if (!oe_n) since_oe <= '0;
      else if (since_oe != 16'hFFFF) since_oe <= since_oe + 1'b1;
      we_len <= we_n ? '0 : we_len + 1'b1;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && oe_n && we_n && !dq_oe));

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_we_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));

  assert_we_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_len == 16'(WP_CYC)));

  assert_dq_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (dq_oe && $past(dq_oe)));

  assert_dq_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

  assert_release_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (since_oe >= 16'(TA_CYC)));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .addr(sram_addr), .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
  .dq_out(sram_dq_out), .dq_oe(sram_dq_oe)
);

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;
  localparam int RD_EXP = 11;
  localparam int WP_EXP = 8;
  localparam int TA_EXP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] sram_addr;
  logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in = 8'hEE;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  async_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // RAM model and bus monitor
  logic [7:0] mem [int unsigned];
  int  rd_age = 0, hold = 0, wlen = 0, cyc = 0;
  int  last_fall = -1, last_period = 0, cs_falls = 0;
  int  busy_run = 0, last_busy = 0;
  bit  prev_cs_n = 1, prev_we_n = 1, prev_dq_oe = 0, prev_ready = 1, drop_pending = 0;
  logic [18:0] prev_addr = '0;

  function automatic logic [7:0] peek(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    bit rd_act;
    cyc++;
    rd_act = !sram_cs_n && !sram_oe_n && sram_we_n;
    if (sram_dq_oe && (rd_act || hold > 0)) chk(0, "R7 bus contention", hold, 0);
    hold   = rd_act ? TA_EXP : (hold > 0 ? hold - 1 : 0);
    rd_age = rd_act ? rd_age + 1 : 0;
    sram_dq_in = (rd_age >= RD_EXP) ? peek(sram_addr) : 8'hEE;
    if (!sram_cs_n && !prev_cs_n && sram_addr != prev_addr)
      chk(0, "R6 address moved under select", sram_addr, prev_addr);
    if (!sram_cs_n && prev_cs_n) begin
      if (last_fall >= 0) last_period = cyc - last_fall;
      last_fall = cyc;
      cs_falls++;
    end
    if (!sram_we_n) begin
      wlen++;
      if (sram_cs_n) chk(0, "R4 WE low outside select", 1, 0);
      if (wlen == 1) chk(prev_dq_oe, "R5 data driven before WE falls", prev_dq_oe, 1);
    end
    if (drop_pending) begin
      chk(!sram_dq_oe, "R5 data released after WE rises", sram_dq_oe, 0);
      drop_pending = 0;
    end
    if (sram_we_n && !prev_we_n) begin
      chk(wlen == WP_EXP, "R4 write pulse length", wlen, WP_EXP);
      chk(sram_dq_oe, "R5 data held one cycle past WE", sram_dq_oe, 1);
      mem[int'(sram_addr)] = sram_dq_out;
      drop_pending = 1;
      wlen = 0;
    end
    if (!req_ready) busy_run++;
    else if (!prev_ready) begin last_busy = busy_run; busy_run = 0; end
    prev_cs_n = sram_cs_n; prev_we_n = sram_we_n; prev_dq_oe = sram_dq_oe;
    prev_addr = sram_addr; prev_ready = req_ready;
  end

  always @(negedge clk) if (rst_n && !sram_cs_n && !sram_dq_oe && sram_we_n && sram_oe_n)
    chk(0, "R4 select low with no strobe", 0, 1);

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [18:0] a, output logic [7:0] d);
    do_req(1'b0, a, 8'h00);
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R3 response pulse one cycle", rsp_valid, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(sram_cs_n && sram_oe_n && sram_we_n, "R1 strobes high in reset",
        {sram_cs_n, sram_oe_n, sram_we_n}, 3'b111);
    chk(!sram_dq_oe && !rsp_valid, "R1 bus released in reset", {sram_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    do_req(1'b1, 19'h12345, 8'hA5);
    chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
    wait_idle();
    chk(last_busy == 11, "R2 write busy cycles", last_busy, 11);
    do_read(19'h12345, d);
    chk(d == 8'hA5, "R3 read returns written byte", d, 8'hA5);
    wait_idle();
    chk(last_busy == 15, "R2 read busy cycles", last_busy, 15);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    do_req(1'b1, 19'h7FFFF, 8'h5A);
    do_req(1'b1, 19'h00000, 8'hC3);
    do_read(19'h7FFFF, d);
    chk(d == 8'h5A, "R3 top address", d, 8'h5A);
    do_read(19'h00000, d);
    chk(d == 8'hC3, "R3 bottom address", d, 8'hC3);
    wait_idle();
  endtask

  task automatic t_back_to_back();
    logic [7:0] d;
    do_req(1'b1, 19'h00ABC, 8'h3C);
    do_req(1'b0, 19'h00ABC, 8'h00);
    @(negedge clk);
    chk(last_period == 12, "R8 write select-to-select spacing", last_period, 12);
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    chk(d == 8'h3C, "R3 read right after write", d, 8'h3C);
    do_req(1'b1, 19'h00ABD, 8'h77);
    @(negedge clk);
    chk(last_period == 16, "R7 read select-to-select spacing", last_period, 16);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    int falls0;
    falls0 = cs_falls;
    do_req(1'b0, 19'h00100, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00200; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk(cs_falls - falls0 == 1, "R9 busy request started no access", cs_falls - falls0, 1);
    do_read(19'h00200, d);
    chk(d == 8'h00, "R9 busy request wrote nothing", d, 8'h00);
    wait_idle();
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_edges();
    t_back_to_back();
    t_busy_ignore();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule